// File: doc/BRIEF.md
# Masked ASID-Tagged Translation Buffer

This block is a fully associative table of address translations. Each slot pairs a virtual page tag with a per-slot page mask, an address-space identifier and a global bit. It also carries two physical halves, one for the even page and one for the odd page of a pair. Each half has its own frame number, 3-bit cache attribute, dirty bit and valid bit.

Two lookup paths read the table combinationally. The lookup port returns a hit flag, the winning slot index and the full slot contents. The probe port returns only the slot index or a miss flag. Both derive the page number from a 32-bit virtual address. Refill logic loads slots through a write port at an explicit index, and a flush command wipes the whole table in one edge. A victim index counter steps through the slots on request, so that refill software has a replacement candidate.

Top module: `masked_tlb`

## Requirements
- R1: The page number used in a compare is virtual address bits [31:13] placed above two zero bits, a 21-bit value; address bits [12:0] do not influence which slot matches.
- R2: A slot's tag matches when the page number and the stored tag agree on every bit where the slot's mask bit is 0; bits set in the mask are not compared.
- R3: A tag match counts only if the slot's global bit is 1 or its stored identifier equals the request identifier.
- R4: A slot with both valid bits at 0 never matches, whatever its other fields hold.
- R5: On a lookup hit, `lk_hit` is 1 and `lk_index` and `lk_entry` present the winning slot. On a miss, all three are 0.
- R6: When several slots match, both the lookup port and the probe port report the lowest-numbered one.
- R7: The probe port drives `pr_miss` to 0 and `pr_index` to the matching slot when a slot matches. Otherwise it drives `pr_miss` to 1 and `pr_index` to 0.
- R8: A write with `wr_index` below ENTRIES stores `wr_entry` into that slot at the next clock edge, with tag bits [1:0] cleared. The slot word is packed from its top bit down as: tag(21), mask(21), identifier(8), global(1), even half, odd half. Each half is packed as frame(20), attribute(3), dirty(1), valid(1).
- R9: A write with `wr_index` at or above ENTRIES changes no slot, and `wr_err` is 1 for exactly the one cycle after that edge.
- R10: A flush clears every field of every slot at the next edge. It takes priority over a write in the same cycle, and that write is neither stored nor flagged.
- R11: The victim counter steps by one on each clock with `vic_adv` high, wraps from ENTRIES-1 to 0, and holds otherwise.
- R12: Reset clears all slots, the victim counter and `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup found a live matching slot |
| lk_index | output | 3 | Winning slot on lookup |
| lk_entry | output | 101 | Contents of the winning slot, or 0 on a miss |
| pr_vaddr | input | 32 | Probe virtual address |
| pr_asid | input | 8 | Probe address-space identifier |
| pr_miss | output | 1 | Probe found no match |
| pr_index | output | 3 | Winning slot on probe |
| wr_en | input | 1 | Load a slot |
| wr_index | input | 4 | Target slot, one bit wider than needed so out-of-range values can be sent |
| wr_entry | input | 101 | Slot word to store |
| wr_err | output | 1 | Previous write was out of range |
| flush | input | 1 | Clear the whole table |
| vic_adv | input | 1 | Step the victim counter |
| vic_index | output | 3 | Current victim slot |

## Verification
The bench aims at the compare corners. These are: a masked field that differs only inside the mask, a difference one bit outside it, and an address that differs only in bits [12:11]. A design that ANDed with the mask rather than its inverse, or that kept those two low page bits, would miss or hit in exactly the wrong cases. Two live slots with the same tag show whether the priority runs from the lowest index or falls to the last one scanned. A fully populated but invalid slot shows whether liveness gates the match. A write at index 8, and a write in the same cycle as a flush, expose a decoder that truncates the index, because it would overwrite slot 0. They also expose an error flag that lingers, or one raised for a flushed write. Stepping the victim counter across its last slot shows whether the wrap is missed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_SH  = 11;
    localparam int VPN_W  = VA_W - PG_SH;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;
    localparam int ATTR_W = 3;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } tlb_half_t;

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [VPN_W-1:0]  mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_entry_t;

    localparam int ENTRY_W = $bits(tlb_entry_t);

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_REJECT,
        OP_CLEAR
    } tbl_op_e;

    function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
        return {va[VA_W-1:PG_SH+2], 2'b00};
    endfunction
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
    import tlb_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              lk_match,
    output logic              pr_match
);
    logic live;
    logic lk_tag_ok, pr_tag_ok;
    logic lk_id_ok, pr_id_ok;

    always_comb begin
        live      = ent.even.valid | ent.odd.valid;
        lk_tag_ok = ((lk_vpn ^ ent.tag) & ~ent.mask) == '0;
        pr_tag_ok = ((pr_vpn ^ ent.tag) & ~ent.mask) == '0;
        lk_id_ok  = ent.glob | (ent.asid == lk_asid);
        pr_id_ok  = ent.glob | (ent.asid == pr_asid);
        lk_match  = live & lk_tag_ok & lk_id_ok;
        pr_match  = live & pr_tag_ok & pr_id_ok;
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= (value == LAST) ? '0 : value + W'(1);
        end
    end
endmodule

// File: rtl/masked_tlb.sv
module masked_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WIX_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_index,
    output logic [ENTRY_W-1:0] lk_entry,
    input  logic [VA_W-1:0]    pr_vaddr,
    input  logic [ASID_W-1:0]  pr_asid,
    output logic               pr_miss,
    output logic [IDX_W-1:0]   pr_index,
    input  logic               wr_en,
    input  logic [WIX_W-1:0]   wr_index,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic               wr_err,
    input  logic               flush,
    input  logic               vic_adv,
    output logic [IDX_W-1:0]   vic_index
);
    tlb_entry_t       slots_q [ENTRIES];
    tlb_entry_t       wr_word;
    tbl_op_e          op;
    logic [ENTRIES-1:0] lk_vec, pr_vec;
    logic [VPN_W-1:0] lk_vpn, pr_vpn;
    logic             pr_any;
    logic             in_range;

    // operation decode
    always_comb begin
        in_range = int'(wr_index) < ENTRIES;
        wr_word  = tlb_entry_t'(wr_entry);
        wr_word.tag[1:0] = 2'b00;
        if (flush)        op = OP_CLEAR;
        else if (!wr_en)  op = OP_HOLD;
        else if (in_range) op = OP_LOAD;
        else              op = OP_REJECT;
    end

    // table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= (op == OP_REJECT);
            unique case (op)
                OP_CLEAR:  for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
                OP_LOAD:   slots_q[wr_index[IDX_W-1:0]] <= wr_word;
                OP_REJECT: ;
                OP_HOLD:   ;
            endcase
        end
    end

    assign lk_vpn = page_of(lk_vaddr);
    assign pr_vpn = page_of(pr_vaddr);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        tlb_match_cell u_cell (
            .ent      (slots_q[g]),
            .lk_vpn   (lk_vpn),
            .lk_asid  (lk_asid),
            .pr_vpn   (pr_vpn),
            .pr_asid  (pr_asid),
            .lk_match (lk_vec[g]),
            .pr_match (pr_vec[g])
        );
    end

    tlb_prio_enc #(.N(ENTRIES)) u_lk_enc (.req(lk_vec), .any(lk_hit), .idx(lk_index));
    tlb_prio_enc #(.N(ENTRIES)) u_pr_enc (.req(pr_vec), .any(pr_any), .idx(pr_index));

    assign pr_miss  = !pr_any;
    assign lk_entry = lk_hit ? ENTRY_W'(slots_q[lk_index]) : '0;

    tlb_victim_ctr #(.N(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (vic_adv),
        .value (vic_index)
    );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WIX_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIX_W-1:0] wr_index,
    input logic             flush,
    input logic             wr_err,
    input logic             vic_adv,
    input logic [IDX_W-1:0] vic_index,
    input logic             lk_hit,
    input logic             pr_miss,
    input logic [IDX_W-1:0] lk_index,
    input logic [IDX_W-1:0] pr_index
);
    logic bad_wr;
    assign bad_wr = wr_en && !flush && (int'(wr_index) >= ENTRIES);

    assert_bad_write_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> wr_err);

    assert_flag_needs_bad_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !wr_err);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && pr_miss));

    assert_victim_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_adv && int'(vic_index) == ENTRIES - 1) |=> vic_index == '0);

    assert_victim_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_adv |=> $stable(vic_index));

    assert_victim_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vic_index) < ENTRIES);

    assert_miss_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_index == '0);

    assert_probe_miss_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pr_miss |-> pr_index == '0);
endmodule

bind masked_tlb tlb_checker #(.ENTRIES(ENTRIES)) u_tlb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_index  (wr_index),
    .flush     (flush),
    .wr_err    (wr_err),
    .vic_adv   (vic_adv),
    .vic_index (vic_index),
    .lk_hit    (lk_hit),
    .pr_miss   (pr_miss),
    .lk_index  (lk_index),
    .pr_index  (pr_index)
);

// File: tb/tb_masked_tlb.sv
module tb_masked_tlb;
    import tlb_pkg::*;

    localparam int ENTRIES = 8;
    localparam int IDX_W = 3;
    localparam int WIX_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [VA_W-1:0]    lk_vaddr = '0;
    logic [ASID_W-1:0]  lk_asid = '0;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_index;
    logic [ENTRY_W-1:0] lk_entry;
    logic [VA_W-1:0]    pr_vaddr = '0;
    logic [ASID_W-1:0]  pr_asid = '0;
    logic               pr_miss;
    logic [IDX_W-1:0]   pr_index;
    logic               wr_en = 1'b0;
    logic [WIX_W-1:0]   wr_index = '0;
    logic [ENTRY_W-1:0] wr_entry = '0;
    logic               wr_err;
    logic               flush = 1'b0;
    logic               vic_adv = 1'b0;
    logic [IDX_W-1:0]   vic_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    masked_tlb #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_hit(lk_hit),
        .lk_index(lk_index), .lk_entry(lk_entry),
        .pr_vaddr(pr_vaddr), .pr_asid(pr_asid), .pr_miss(pr_miss),
        .pr_index(pr_index),
        .wr_en(wr_en), .wr_index(wr_index), .wr_entry(wr_entry), .wr_err(wr_err),
        .flush(flush), .vic_adv(vic_adv), .vic_index(vic_index)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic tlb_entry_t mk(input logic [VPN_W-1:0] tag,
                                      input logic [VPN_W-1:0] mask,
                                      input logic [ASID_W-1:0] asid, input logic g,
                                      input logic [PFN_W-1:0] pfn0, input logic v0,
                                      input logic [PFN_W-1:0] pfn1, input logic v1);
        tlb_entry_t e;
        e.tag = tag; e.mask = mask; e.asid = asid; e.glob = g;
        e.even.pfn = pfn0; e.even.attr = 3'd2; e.even.dirty = 1'b1; e.even.valid = v0;
        e.odd.pfn  = pfn1; e.odd.attr  = 3'd3; e.odd.dirty  = 1'b0; e.odd.valid  = v1;
        return e;
    endfunction

    function automatic logic [VA_W-1:0] va(input logic [VPN_W-1:0] vpn,
                                           input logic [12:0] low);
        return {vpn[VPN_W-1:2], low};
    endfunction

    task automatic write_slot(input int idx, input tlb_entry_t e);
        @(negedge clk);
        wr_en = 1'b1; wr_index = WIX_W'(idx); wr_entry = ENTRY_W'(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [VA_W-1:0] a, input logic [ASID_W-1:0] id);
        lk_vaddr = a; lk_asid = id; pr_vaddr = a; pr_asid = id;
        #1;
    endtask

    task automatic expect_hit(input string req, input int idx, input tlb_entry_t e);
        check(lk_hit === 1'b1, req, lk_hit, 1);
        check(lk_index === IDX_W'(idx), req, lk_index, idx);
        check(lk_entry === ENTRY_W'(e), req, lk_entry, e);
        check(pr_miss === 1'b0 && pr_index === IDX_W'(idx), req, {pr_miss, pr_index}, idx);
    endtask

    task automatic expect_miss(input string req);
        check(lk_hit === 1'b0 && lk_index === '0, req, {lk_hit, lk_index}, 0);
        check(lk_entry === '0, req, lk_entry, 0);
        check(pr_miss === 1'b1 && pr_index === '0, req, {pr_miss, pr_index}, 8);
    endtask

    task automatic t_reset;
        look(32'h0, 8'h0);
        expect_miss("R12 reset table empty");
        check(vic_index === '0, "R12 reset victim", vic_index, 0);
        check(wr_err === 1'b0, "R12 reset error flag", wr_err, 0);
    endtask

    task automatic t_basic;
        tlb_entry_t e = mk(21'h01234, '0, 8'd5, 1'b0, 20'hAAAAA, 1, 20'hBBBBB, 1);
        write_slot(2, e);
        look(va(21'h01234, 13'h0040), 8'd5);
        expect_hit("R5 R8 basic hit", 2, e);
        look(va(21'h01234, 13'h0040), 8'd6);
        expect_miss("R3 identifier mismatch");
        look(va(21'h01234, 13'h1FFF), 8'd5);
        expect_hit("R1 low address bits ignored", 2, e);
        look(va(21'h01230, 13'h0), 8'd5);
        expect_miss("R1 address bit 13 compared");
    endtask

    task automatic t_global;
        tlb_entry_t e = mk(21'h0AB00, '0, 8'd9, 1'b1, 20'h11111, 1, 20'h22222, 0);
        write_slot(3, e);
        look(va(21'h0AB00, 13'h0), 8'd1);
        expect_hit("R3 global ignores identifier", 3, e);
    endtask

    task automatic t_mask;
        tlb_entry_t e = mk(21'h10000, 21'h0003C, 8'd7, 1'b0, 20'h33333, 0, 20'h44444, 1);
        write_slot(4, e);
        look(va(21'h1003C, 13'h0), 8'd7);
        expect_hit("R2 masked bits not compared", 4, e);
        look(va(21'h10100, 13'h0), 8'd7);
        expect_miss("R2 unmasked bit compared");
    endtask

    task automatic t_not_live;
        tlb_entry_t e = mk(21'h05550, '0, 8'd0, 1'b1, 20'h55555, 0, 20'h66666, 0);
        write_slot(5, e);
        look(va(21'h05550, 13'h0), 8'd0);
        expect_miss("R4 invalid slot never matches");
    endtask

    task automatic t_priority;
        tlb_entry_t e6 = mk(21'h07770, '0, 8'd0, 1'b1, 20'h77777, 1, 20'h0, 0);
        tlb_entry_t e1 = mk(21'h07770, '0, 8'd0, 1'b1, 20'h12121, 1, 20'h0, 0);
        write_slot(6, e6);
        write_slot(1, e1);
        look(va(21'h07770, 13'h0), 8'd3);
        expect_hit("R6 R7 lowest index wins", 1, e1);
    endtask

    task automatic t_tag_clear;
        tlb_entry_t e = mk(21'h02223, '0, 8'd4, 1'b0, 20'h0F0F0, 1, 20'h0, 0);
        tlb_entry_t s = e;
        s.tag = 21'h02220;
        write_slot(0, e);
        look(va(21'h02220, 13'h0), 8'd4);
        expect_hit("R8 stored tag low bits cleared", 0, s);
    endtask

    task automatic t_bad_write;
        tlb_entry_t e = mk(21'h0EEE0, '0, 8'd0, 1'b1, 20'h9, 1, 20'h9, 1);
        tlb_entry_t s0 = mk(21'h02220, '0, 8'd4, 1'b0, 20'h0F0F0, 1, 20'h0, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 4'd8; wr_entry = ENTRY_W'(e);
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_err === 1'b1, "R9 error flag raised", wr_err, 1);
        look(va(21'h0EEE0, 13'h0), 8'd0);
        expect_miss("R9 out-of-range write not stored");
        look(va(21'h02220, 13'h0), 8'd4);
        expect_hit("R9 slot 0 untouched", 0, s0);
        @(negedge clk);
        check(wr_err === 1'b0, "R9 error flag one cycle", wr_err, 0);
    endtask

    task automatic t_flush;
        tlb_entry_t e = mk(21'h01234, '0, 8'd5, 1'b0, 20'hAAAAA, 1, 20'hBBBBB, 1);
        @(negedge clk);
        flush = 1'b1; wr_en = 1'b1; wr_index = 4'd2; wr_entry = ENTRY_W'(e);
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        check(wr_err === 1'b0, "R10 flushed write not flagged", wr_err, 0);
        look(va(21'h01234, 13'h0), 8'd5);
        expect_miss("R10 flush wins over write");
        look(va(21'h07770, 13'h0), 8'd0);
        expect_miss("R10 flush clears slot 1");
        look(va(21'h0AB00, 13'h0), 8'd0);
        expect_miss("R10 flush clears global slot");
    endtask

    task automatic t_victim;
        for (int k = 1; k <= ENTRIES; k++) begin
            @(negedge clk);
            vic_adv = 1'b1;
            @(negedge clk);
            vic_adv = 1'b0;
            check(vic_index === IDX_W'(k % ENTRIES), "R11 victim step", vic_index, k % ENTRIES);
        end
        @(negedge clk);
        @(negedge clk);
        check(vic_index === '0, "R11 victim holds", vic_index, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_global();
        t_mask();
        t_not_live();
        t_priority();
        t_tag_clear();
        t_bad_write();
        t_flush();
        t_victim();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule